// File: doc/BRIEF.md
# Triple timer counter

This peripheral holds three independent timer channels behind one 32-bit register bus. Every channel has a divider that can be switched on or off. The divider feeds a counter that counts up or down. The counter either runs over its full width or wraps at a programmed interval. Three comparators per channel raise flags when the count lands on their values. A six-bit status word collects the wrap, match and event flags. Reading the status word returns it and then clears it. Each channel drives one interrupt line, which is the OR of its status bits that are enabled.

Software reaches the registers with single-cycle read and write strobes. The map is interleaved: each register kind takes three consecutive words, one word per channel. Read data is combinational from the address during the read strobe. The event control register and the event count register are plain storage with no event logic behind them.

Top module: `tri_timer`

## Requirements
- R1: A byte offset selects word w = offset>>2. The channel is w mod 3 and the register kind is w div 3. Kind order from offset 0x00 upward: clock control, counter control, count value, interval, match 0, match 1, match 2, status, interrupt enable, event control, event count. For example, channel 1's match 0 is at 0x34. Offsets from 0x84 upward read 0, and writes to them change nothing.
- R2: After reset, counter control reads 0x21 in every channel. Every other register reads 0, and all interrupt lines are low.
- R3: Clock control stores only bits 5:0. When bit 0 is 1, the counter advances once every 2^(N+1) clocks, where N is bits 4:1. The divider restarts when clock control is written, so the first step comes 2^(N+1) clocks after that write. When bit 0 is 0, the counter may advance on every clock.
- R4: Counter control stores bits 5:0. The bits are: 0 = stop, 1 = interval mode, 2 = count down, 3 = match enable. A stopped counter holds its value.
- R5: Writing counter control with bit 4 set clears the count to 0. This takes priority over a step in the same cycle. Bit 4 always reads back as 0.
- R6: When counting up, the count wraps to 0 after the top value. The top value is the interval register in interval mode and 2^WIDTH-1 otherwise. A wrap sets status bit 0 in interval mode and status bit 4 otherwise.
- R7: When counting down, the count wraps from 0 to the top value and sets the same wrap bits as in R6.
- R8: With match enable set, a step whose new count equals match register i sets status bit 1+i. This includes a new count of 0 reached by a wrap. With match enable clear, no match bit is set.
- R9: A status read returns the value before clearing and then clears all bits. A flag raised in the same cycle as the read survives the clear. Writes to status have no effect.
- R10: Interrupt enable stores bits 5:0. A channel's interrupt output is high exactly when its status AND its enable is non-zero.
- R11: Writes to interval and match registers are cut to WIDTH bits, and event control keeps bits 2:0. The count value and event count registers are read-only, and event count reads 0.
- R12: Channels are independent. Running or writing one channel does not change another channel's count or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| irq | output | NCH | One interrupt line per channel |

## Verification
The assertions check on every cycle the properties that follow from a single access:
- bits that are never stored read back as zero in clock control, counter control, status and the WIDTH-limited registers;
- unmapped offsets return zero;
- a channel whose enable has just been written to zero drops its interrupt on the next cycle.

Only the bench scenarios can show behaviour that builds up over many cycles:
- prescaler timing;
- interval and full-width wraps in both directions;
- match flags, including a match at zero reached through a wrap;
- a clear-on-read that coincides with a new match flag;
- isolation between channels.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

    // Register kinds in address order (kind = word div channel count)
    typedef enum logic [3:0] {
        K_CLK = 4'd0,
        K_CTL = 4'd1,
        K_VAL = 4'd2,
        K_IVL = 4'd3,
        K_M0  = 4'd4,
        K_M1  = 4'd5,
        K_M2  = 4'd6,
        K_STS = 4'd7,
        K_IEN = 4'd8,
        K_EVC = 4'd9,
        K_EVN = 4'd10
    } reg_kind_e;

    localparam int NKIND  = 11;
    localparam int NMATCH = 3;

    // Clock control fields
    localparam int CK_EN     = 0;
    localparam int CK_DIV_LO = 1;
    localparam int CK_DIV_HI = 4;
    localparam int PS_W      = CK_DIV_HI - CK_DIV_LO + 1;
    localparam int PCW       = 2 ** PS_W;

    // Counter control fields
    localparam int CT_DIS  = 0;
    localparam int CT_IVL  = 1;
    localparam int CT_DOWN = 2;
    localparam int CT_MEN  = 3;
    localparam int CT_CLR  = 4;

    // Status fields
    localparam int ST_IVL = 0;
    localparam int ST_M0  = 1;
    localparam int ST_OVF = 4;

endpackage

// File: rtl/tri_timer_presc.sv
module tri_timer_presc
    import tri_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            enable,
    input  logic [PS_W-1:0] shift,
    output logic            tick
);

    logic [PCW-1:0] pcnt_d, pcnt_q;
    logic [PCW:0]   span;
    logic [PCW-1:0] mask;

    always_comb begin
        span   = ((PCW+1)'(1) << ({1'b0, shift} + (PS_W+1)'(1))) - (PCW+1)'(1);
        mask   = span[PCW-1:0];
        tick   = !enable || ((pcnt_q & mask) == mask);
        pcnt_d = restart ? '0 : pcnt_q + PCW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

endmodule

// File: rtl/tri_timer_step.sv
module tri_timer_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] top,
    input  logic             down,
    input  logic             advance,
    output logic [WIDTH-1:0] nxt,
    output logic             wrapped
);

    always_comb begin
        nxt     = cnt;
        wrapped = 1'b0;
        if (advance) begin
            if (down) begin
                if (cnt == '0) begin
                    nxt     = top;
                    wrapped = 1'b1;
                end else begin
                    nxt = cnt - WIDTH'(1);
                end
            end else begin
                if (cnt >= top) begin
                    nxt     = '0;
                    wrapped = 1'b1;
                end else begin
                    nxt = cnt + WIDTH'(1);
                end
            end
        end
    end

endmodule

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
    import tri_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  reg_kind_e        kind,
    input  logic [WIDTH-1:0] wdata,
    output logic [31:0]      rdata,
    output logic             irq
);

    typedef struct packed {
        logic [5:0]                   clk_ctl;
        logic [5:0]                   ctl;
        logic [WIDTH-1:0]             cnt;
        logic [WIDTH-1:0]             ivl;
        logic [NMATCH-1:0][WIDTH-1:0] mtc;
        logic [5:0]                   sts;
        logic [5:0]                   ien;
        logic [2:0]                   evc;
    } chan_t;

    chan_t            st_d, st_q;
    logic             tick, advance, wrapped, ps_restart;
    logic [WIDTH-1:0] top, nxt;
    logic [5:0]       flags;

    assign ps_restart = wr_en && (kind == K_CLK);
    assign advance    = tick && !st_q.ctl[CT_DIS];
    assign top        = st_q.ctl[CT_IVL] ? st_q.ivl : '1;

    tri_timer_presc u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ps_restart),
        .enable  (st_q.clk_ctl[CK_EN]),
        .shift   (st_q.clk_ctl[CK_DIV_HI:CK_DIV_LO]),
        .tick    (tick)
    );

    tri_timer_step #(.WIDTH(WIDTH)) u_step (
        .cnt     (st_q.cnt),
        .top     (top),
        .down    (st_q.ctl[CT_DOWN]),
        .advance (advance),
        .nxt     (nxt),
        .wrapped (wrapped)
    );

    // Flag events of this cycle
    always_comb begin
        flags = '0;
        if (wrapped) begin
            if (st_q.ctl[CT_IVL]) flags[ST_IVL] = 1'b1;
            else                  flags[ST_OVF] = 1'b1;
        end
        for (int i = 0; i < NMATCH; i++) begin
            if (advance && st_q.ctl[CT_MEN] && (nxt == st_q.mtc[i]))
                flags[ST_M0+i] = 1'b1;
        end
    end

    // Next state
    always_comb begin
        st_d     = st_q;
        st_d.cnt = nxt;
        if (wr_en) begin
            case (kind)
                K_CLK: st_d.clk_ctl = wdata[5:0];
                K_CTL: begin
                    st_d.ctl         = wdata[5:0];
                    st_d.ctl[CT_CLR] = 1'b0;
                    if (wdata[CT_CLR]) st_d.cnt = '0;
                end
                K_IVL: st_d.ivl    = wdata;
                K_M0:  st_d.mtc[0] = wdata;
                K_M1:  st_d.mtc[1] = wdata;
                K_M2:  st_d.mtc[2] = wdata;
                K_IEN: st_d.ien    = wdata[5:0];
                K_EVC: st_d.evc    = wdata[2:0];
                default: ;
            endcase
        end
        st_d.sts = ((rd_en && (kind == K_STS)) ? 6'd0 : st_q.sts) | flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ctl <= 6'h21;
        end else begin
            st_q <= st_d;
        end
    end

    // Read-back
    always_comb begin
        case (kind)
            K_CLK:   rdata = 32'(st_q.clk_ctl);
            K_CTL:   rdata = 32'(st_q.ctl);
            K_VAL:   rdata = 32'(st_q.cnt);
            K_IVL:   rdata = 32'(st_q.ivl);
            K_M0:    rdata = 32'(st_q.mtc[0]);
            K_M1:    rdata = 32'(st_q.mtc[1]);
            K_M2:    rdata = 32'(st_q.mtc[2]);
            K_STS:   rdata = 32'(st_q.sts);
            K_IEN:   rdata = 32'(st_q.ien);
            K_EVC:   rdata = 32'(st_q.evc);
            default: rdata = '0;
        endcase
    end

    assign irq = |(st_q.sts & st_q.ien);

endmodule

// File: rtl/tri_timer.sv
module tri_timer
    import tri_timer_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int NCH    = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NCH-1:0]    irq
);

    localparam int WW = ADDR_W - 2;
    localparam logic [WW-1:0] NCH_W   = WW'(NCH);
    localparam logic [WW-1:0] NKIND_W = WW'(NKIND);

    logic [WW-1:0] word, kind_idx, chan_idx;
    logic          mapped;
    reg_kind_e     kind;
    logic [31:0]   ch_rdata [NCH];
    logic          unused_bits;

    assign word        = addr[ADDR_W-1:2];
    assign kind_idx    = word / NCH_W;
    assign chan_idx    = word % NCH_W;
    assign mapped      = kind_idx < NKIND_W;
    assign kind        = reg_kind_e'(kind_idx[3:0]);
    assign unused_bits = ^{addr[1:0], wdata[31:WIDTH]};

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic sel;
        assign sel = mapped && (chan_idx == WW'(c));
        tri_timer_chan #(.WIDTH(WIDTH)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en && sel),
            .rd_en (rd_en && sel),
            .kind  (kind),
            .wdata (wdata[WIDTH-1:0]),
            .rdata (ch_rdata[c]),
            .irq   (irq[c])
        );
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (mapped && (chan_idx == WW'(c))) rdata = ch_rdata[c];
        end
    end

endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk #(
    parameter int WIDTH  = 16,
    parameter int NCH    = 3,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [NCH-1:0]    irq
);

    int unsigned word_i, kidx, cidx;
    logic        unused_chk;

    assign word_i     = 32'(addr[ADDR_W-1:2]);
    assign kidx       = word_i / NCH;
    assign cidx       = word_i % NCH;
    assign unused_chk = ^{addr[1:0], wdata[31:6]};

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (kidx >= 11) |-> rdata == '0); // R1

    AST_CLKCTL_SIX_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (kidx == 0) |-> rdata[31:6] == '0); // R3

    AST_CLR_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (kidx == 1) |-> (rdata[4] == 1'b0) && (rdata[31:6] == '0)); // R5

    AST_STATUS_SIX_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (kidx == 7) |-> rdata[31:6] == '0); // R9

    if (WIDTH < 32) begin : g_wmask
        AST_WIDTH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en && (kidx >= 2) && (kidx <= 6) |-> rdata[31:WIDTH] == '0); // R11
    end

    for (genvar c = 0; c < NCH; c++) begin : g_irq
        AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && (kidx == 8) && (cidx == c) && (wdata[5:0] == 6'd0)
            |=> !irq[c]); // R10
    end

endmodule

bind tri_timer tri_timer_chk #(.WIDTH(WIDTH), .NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
);

// File: tb/tri_timer_test.sv
module tri_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    tri_timer uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    // {op[1:0], req[3:0], addr[7:0], data[31:0], expect[31:0]}
    // op 0 = write, 1 = read and compare, 2 = idle data cycles
    localparam int NV = 64;
    localparam logic [77:0] VEC [NV] = '{
        {2'd1, 4'd2,  8'h0C, 32'h0, 32'h21},          // R2 ctl ch0
        {2'd1, 4'd2,  8'h10, 32'h0, 32'h21},          // R2 ctl ch1
        {2'd1, 4'd2,  8'h14, 32'h0, 32'h21},          // R2 ctl ch2
        {2'd1, 4'd2,  8'h18, 32'h0, 32'h0},           // R2 count
        {2'd0, 4'd4,  8'h0C, 32'hFF, 32'h0},
        {2'd1, 4'd5,  8'h0C, 32'h0, 32'h2F},          // R4 R5 six bits, clear bit dropped
        {2'd0, 4'd3,  8'h00, 32'hFFFFFFC3, 32'h0},
        {2'd1, 4'd3,  8'h00, 32'h0, 32'h03},          // R3
        {2'd0, 4'd11, 8'h24, 32'h12345678, 32'h0},
        {2'd1, 4'd11, 8'h24, 32'h0, 32'h5678},        // R11
        {2'd0, 4'd11, 8'h30, 32'hABCD0005, 32'h0},
        {2'd1, 4'd11, 8'h30, 32'h0, 32'h0005},        // R11
        {2'd0, 4'd11, 8'h6C, 32'hFF, 32'h0},
        {2'd1, 4'd11, 8'h6C, 32'h0, 32'h07},          // R11
        {2'd1, 4'd11, 8'h78, 32'h0, 32'h0},           // R11 event count
        {2'd0, 4'd11, 8'h18, 32'h55, 32'h0},
        {2'd1, 4'd11, 8'h18, 32'h0, 32'h0},           // R11 count read-only
        {2'd0, 4'd10, 8'h60, 32'hFFFF, 32'h0},
        {2'd1, 4'd10, 8'h60, 32'h0, 32'h3F},          // R10
        {2'd1, 4'd1,  8'h84, 32'h0, 32'h0},           // R1 unmapped
        {2'd0, 4'd1,  8'h84, 32'hFFFFFFFF, 32'h0},
        {2'd1, 4'd1,  8'h3C, 32'h0, 32'h0},           // R1 nothing changed
        {2'd0, 4'd9,  8'h54, 32'h3F, 32'h0},
        {2'd1, 4'd9,  8'h54, 32'h0, 32'h0},           // R9 write ignored
        {2'd0, 4'd6,  8'h00, 32'h0, 32'h0},
        {2'd0, 4'd6,  8'h24, 32'h4, 32'h0},
        {2'd0, 4'd6,  8'h30, 32'h2, 32'h0},
        {2'd0, 4'd6,  8'h3C, 32'h0, 32'h0},
        {2'd0, 4'd6,  8'h48, 32'h9, 32'h0},
        {2'd0, 4'd6,  8'h0C, 32'h0A, 32'h0},          // interval, match en, up
        {2'd2, 4'd6,  8'h00, 32'd3, 32'h0},
        {2'd1, 4'd6,  8'h18, 32'h0, 32'h3},           // R6 count
        {2'd2, 4'd6,  8'h00, 32'd1, 32'h0},
        {2'd1, 4'd8,  8'h54, 32'h0, 32'h07},          // R6 R8 wrap + m0 + m1 at zero
        {2'd1, 4'd9,  8'h54, 32'h0, 32'h0},           // R9 cleared
        {2'd1, 4'd9,  8'h54, 32'h0, 32'h02},          // R9 flag kept over clear
        {2'd0, 4'd4,  8'h0C, 32'h01, 32'h0},
        {2'd2, 4'd4,  8'h00, 32'd2, 32'h0},
        {2'd1, 4'd4,  8'h18, 32'h0, 32'h4},           // R4 stopped holds
        {2'd1, 4'd4,  8'h54, 32'h0, 32'h0},           // R4 no flags when stopped
        {2'd0, 4'd5,  8'h0C, 32'h11, 32'h0},
        {2'd0, 4'd3,  8'h00, 32'h03, 32'h0},          // divide by 4
        {2'd0, 4'd3,  8'h0C, 32'h00, 32'h0},
        {2'd2, 4'd3,  8'h00, 32'd7, 32'h0},
        {2'd1, 4'd3,  8'h18, 32'h0, 32'h2},           // R3 prescaled
        {2'd0, 4'd5,  8'h0C, 32'h11, 32'h0},
        {2'd1, 4'd5,  8'h18, 32'h0, 32'h0},           // R5 reset wins
        {2'd0, 4'd3,  8'h00, 32'h0, 32'h0},
        {2'd0, 4'd8,  8'h34, 32'hFFFF, 32'h0},
        {2'd0, 4'd7,  8'h64, 32'h10, 32'h0},
        {2'd0, 4'd7,  8'h10, 32'h04, 32'h0},          // ch1 down, free
        {2'd2, 4'd7,  8'h00, 32'd2, 32'h0},
        {2'd1, 4'd7,  8'h1C, 32'h0, 32'hFFFE},        // R7
        {2'd1, 4'd8,  8'h58, 32'h0, 32'h10},          // R7 R8 overflow, no match
        {2'd0, 4'd5,  8'h10, 32'h11, 32'h0},
        {2'd1, 4'd5,  8'h1C, 32'h0, 32'h0},           // R5
        {2'd0, 4'd6,  8'h14, 32'h00, 32'h0},          // ch2 up, free
        {2'd2, 4'd6,  8'h00, 32'd65535, 32'h0},
        {2'd1, 4'd6,  8'h20, 32'h0, 32'hFFFF},        // R6 full width
        {2'd1, 4'd6,  8'h5C, 32'h0, 32'h10},          // R6 overflow bit
        {2'd0, 4'd12, 8'h14, 32'h01, 32'h0},
        {2'd1, 4'd12, 8'h18, 32'h0, 32'h0},           // R12 ch0 untouched
        {2'd1, 4'd12, 8'h1C, 32'h0, 32'h0},           // R12 ch1 untouched
        {2'd1, 4'd12, 8'h58, 32'h0, 32'h0}            // R12 ch1 status
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(2, 32'(irq), 32'h0, "irq after reset"); // R2

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][77:76])
                2'd0: wr(VEC[i][71:64], VEC[i][63:32]);
                2'd1: begin
                    rd(VEC[i][71:64], got);
                    check(int'(VEC[i][75:72]), got, VEC[i][31:0],
                          $sformatf("vector %0d addr %h", i, VEC[i][71:64]));
                end
                default: idle(int'(VEC[i][63:32]));
            endcase
        end

        // R10 / R9 directed interrupt tests on channel 0
        wr(8'h60, 32'h02);
        wr(8'h30, 32'h1);
        wr(8'h0C, 32'h08);
        check(10, 32'(irq), 32'h0, "irq before match");
        idle(1);
        check(10, 32'(irq), 32'h1, "irq on match 0");
        wr(8'h54, 32'h0);
        check(9, 32'(irq), 32'h1, "status write ignored");
        wr(8'h60, 32'h0);
        check(10, 32'(irq), 32'h0, "irq masked by enable");
        wr(8'h60, 32'h02);
        check(10, 32'(irq), 32'h1, "irq unmasked");
        rd(8'h54, got);
        check(9, got, 32'h02, "status before clear");
        check(9, 32'(irq), 32'h0, "irq after clear on read");
        wr(8'h0C, 32'h11);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule